// File: doc/BRIEF.md
# Multi-Mode Preset Up/Down Counter

This block is the counting core of one channel of a position-measurement peripheral. An upstream decoder supplies a one-cycle step strobe and a direction level. A register file supplies a preset value, a write strobe for that value, a two-bit count-mode field and a few command strobes. The counter is 24 bits wide. It can be changed directly in only one way: load the preset register, then issue a transfer command. An index event can make the same transfer when the index-load enable is set.

Four wrap behaviours can be selected: free-running wrap, clamping between zero and the preset, stop-after-wrap, and divide-by-(preset+1). Carry and borrow are separate sticky flags. Software reads their XOR as a 25th count bit. A single clear command resets the carry, borrow, compare and sign flags together. A direction flag records the direction of the most recent step.

All outputs are registered. Each change appears on the first rising clock edge after the input that causes it.

Top module: `updn_counter`

## Requirements
- R1: After reset the count is 0, carry, borrow, compare and sign are 0, the direction flag is 1, and the preset register holds 0, so a transfer right after reset leaves the count at 0.
- R2: A pulse on `presetWr` stores `presetIn` in the preset register and never changes the count. With no step and no transfer, the count holds.
- R3: `loadCmd`, or `idxEvent` while `idxLoadEn` is 1, copies the preset register into the count on the next edge. A transfer takes priority over a step in the same cycle. `idxEvent` with `idxLoadEn` at 0 has no effect.
- R4: With `modeSel` = 0 (normal), a step up from 0xFFFFFF gives 0 and sets carry. A step down from 0 gives 0xFFFFFF and sets borrow. All other steps add or subtract 1.
- R5: With `modeSel` = 1 (range limit), a step up while the count equals the preset (or 0xFFFFFF) holds the count and sets carry. A step down at 0 holds the count and sets borrow.
- R6: With `modeSel` = 2 (non-recycle), wraps behave as in R4. After a wrap, further steps leave the count unchanged until the next transfer.
- R7: With `modeSel` = 3 (modulo-N), a step up while the count equals the preset (or 0xFFFFFF) gives 0 and sets carry. A step down at 0 reloads the preset and sets borrow.
- R8: Carry and borrow are sticky and independent, so the XOR of the two is a 25th count bit. `clrFlags` clears carry, borrow, compare and sign. A flag-setting step in the same cycle as `clrFlags` wins.
- R9: The compare flag sets when a step leaves the count equal to the preset register. A transfer alone does not set it.
- R10: The sign flag sets on every borrow event and clears on every carry event or on `clrFlags`.
- R11: On every step strobe, including one ignored by R6, the direction flag takes the value of `cntUp` (1 = up, 0 = down). Otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cntStep | input | 1 | One-cycle count strobe from the decoder |
| cntUp | input | 1 | Direction of the step: 1 up, 0 down |
| presetIn | input | 24 | Value for the preset register |
| presetWr | input | 1 | Write strobe for the preset register |
| modeSel | input | 2 | 0 normal, 1 range limit, 2 non-recycle, 3 modulo-N |
| loadCmd | input | 1 | Transfer the preset register into the count |
| idxEvent | input | 1 | Qualified index pulse |
| idxLoadEn | input | 1 | Lets `idxEvent` make the transfer |
| clrFlags | input | 1 | Clear carry, borrow, compare and sign |
| countOut | output | 24 | Current count |
| carryFlag | output | 1 | Sticky up-wrap / upper-limit flag |
| borrowFlag | output | 1 | Sticky down-wrap / lower-limit flag |
| cmpFlag | output | 1 | Sticky count-equals-preset flag |
| signFlag | output | 1 | Set by borrow, cleared by carry |
| dirFlag | output | 1 | Direction of the last step |

## Verification
A wrong wrap decision shows on the edge right after the faulty step: the count lands on the wrong boundary value, or carry and borrow come up in the wrong pair. A stuck stop-after-wrap latch in non-recycle mode is visible on the next step, because the count either moves when it should hold or stays frozen after a transfer. A wrong preset-register value stays hidden until a transfer, a modulo-N reload or a compare. The bench therefore checks the count on the cycle after each of these events.

// File: rtl/updn_counter_pkg.sv
package updn_counter_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_RANGE   = 2'd1,
    MODE_NORECYC = 2'd2,
    MODE_MODN    = 2'd3
  } cntMode_e;

  typedef enum logic [2:0] {
    SEL_HOLD   = 3'd0,
    SEL_INC    = 3'd1,
    SEL_DEC    = 3'd2,
    SEL_ZERO   = 3'd3,
    SEL_MAX    = 3'd4,
    SEL_PRESET = 3'd5
  } cntSel_e;

  typedef struct packed {
    cntSel_e sel;
    logic    stepTaken;
    logic    setCarry;
    logic    setBorrow;
    logic    clr;
    logic    dirWr;
  } ctlStrobe_t;
endpackage

// File: rtl/updn_counter_ctl.sv
module updn_counter_ctl
  import updn_counter_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cntStep,
  input  logic             cntUp,
  input  logic [1:0]       modeSel,
  input  logic             loadReq,
  input  logic             clrFlags,
  input  logic [CNT_W-1:0] cntQ,
  input  logic [CNT_W-1:0] presetQ,
  output ctlStrobe_t       strobe
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  cntMode_e mode;
  logic     haltQ;
  logic     isMax, isZero, atPreset, blocked;

  assign mode     = cntMode_e'(modeSel);
  assign isMax    = (cntQ == CNT_MAX);
  assign isZero   = (cntQ == '0);
  assign atPreset = (cntQ == presetQ);
  assign blocked  = (mode == MODE_NORECYC) && haltQ;

  always_comb begin
    strobe           = '0;
    strobe.sel       = SEL_HOLD;
    strobe.clr       = clrFlags;
    strobe.dirWr     = cntStep;
    if (loadReq) begin
      strobe.sel = SEL_PRESET;
    end else if (cntStep && !blocked) begin
      strobe.stepTaken = 1'b1;
      unique case (mode)
        MODE_RANGE: begin
          if (cntUp) begin
            if (atPreset || isMax) strobe.setCarry = 1'b1;
            else                   strobe.sel = SEL_INC;
          end else begin
            if (isZero) strobe.setBorrow = 1'b1;
            else        strobe.sel = SEL_DEC;
          end
        end
        MODE_MODN: begin
          if (cntUp) begin
            if (atPreset || isMax) begin
              strobe.sel      = SEL_ZERO;
              strobe.setCarry = 1'b1;
            end else strobe.sel = SEL_INC;
          end else begin
            if (isZero) begin
              strobe.sel       = SEL_PRESET;
              strobe.setBorrow = 1'b1;
            end else strobe.sel = SEL_DEC;
          end
        end
        default: begin
          if (cntUp) begin
            if (isMax) begin
              strobe.sel      = SEL_ZERO;
              strobe.setCarry = 1'b1;
            end else strobe.sel = SEL_INC;
          end else begin
            if (isZero) begin
              strobe.sel       = SEL_MAX;
              strobe.setBorrow = 1'b1;
            end else strobe.sel = SEL_DEC;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       haltQ <= 1'b0;
    else if (loadReq) haltQ <= 1'b0;
    else if (mode == MODE_NORECYC && strobe.stepTaken &&
             (strobe.setCarry || strobe.setBorrow))
      haltQ <= 1'b1;
  end
endmodule

// File: rtl/updn_counter_dp.sv
module updn_counter_dp
  import updn_counter_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStrobe_t       strobe,
  input  logic             cntUp,
  input  logic             presetWr,
  input  logic [CNT_W-1:0] presetIn,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] presetQ,
  output logic             carryQ,
  output logic             borrowQ,
  output logic             cmpQ,
  output logic             signQ,
  output logic             dirQ
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cntNext;

  always_comb begin
    unique case (strobe.sel)
      SEL_INC:    cntNext = cntQ + 1'b1;
      SEL_DEC:    cntNext = cntQ - 1'b1;
      SEL_ZERO:   cntNext = '0;
      SEL_MAX:    cntNext = CNT_MAX;
      SEL_PRESET: cntNext = presetQ;
      default:    cntNext = cntQ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntQ    <= '0;
      presetQ <= '0;
      carryQ  <= 1'b0;
      borrowQ <= 1'b0;
      cmpQ    <= 1'b0;
      signQ   <= 1'b0;
      dirQ    <= 1'b1;
    end else begin
      cntQ <= cntNext;
      if (presetWr)     presetQ <= presetIn;
      if (strobe.dirWr) dirQ    <= cntUp;
      carryQ  <= strobe.setCarry  | (carryQ  & ~strobe.clr);
      borrowQ <= strobe.setBorrow | (borrowQ & ~strobe.clr);
      cmpQ    <= (strobe.stepTaken && (cntNext == presetQ)) | (cmpQ & ~strobe.clr);
      if (strobe.setBorrow)                  signQ <= 1'b1;
      else if (strobe.setCarry || strobe.clr) signQ <= 1'b0;
    end
  end
endmodule

// File: rtl/updn_counter.sv
module updn_counter
  import updn_counter_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cntStep,
  input  logic             cntUp,
  input  logic [CNT_W-1:0] presetIn,
  input  logic             presetWr,
  input  logic [1:0]       modeSel,
  input  logic             loadCmd,
  input  logic             idxEvent,
  input  logic             idxLoadEn,
  input  logic             clrFlags,
  output logic [CNT_W-1:0] countOut,
  output logic             carryFlag,
  output logic             borrowFlag,
  output logic             cmpFlag,
  output logic             signFlag,
  output logic             dirFlag
);
  ctlStrobe_t       strobe;
  logic [CNT_W-1:0] presetVal;
  logic             loadReq;

  assign loadReq = loadCmd || (idxEvent && idxLoadEn);

  updn_counter_ctl #(.CNT_W(CNT_W)) uCtl (
    .clk(clk), .rst_n(rst_n), .cntStep(cntStep), .cntUp(cntUp),
    .modeSel(modeSel), .loadReq(loadReq), .clrFlags(clrFlags),
    .cntQ(countOut), .presetQ(presetVal), .strobe(strobe)
  );

  updn_counter_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cntUp(cntUp),
    .presetWr(presetWr), .presetIn(presetIn), .cntQ(countOut),
    .presetQ(presetVal), .carryQ(carryFlag), .borrowQ(borrowFlag),
    .cmpQ(cmpFlag), .signQ(signFlag), .dirQ(dirFlag)
  );
endmodule

// File: rtl/updn_counter_chk.sv
module updn_counter_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cntStep,
  input logic             cntUp,
  input logic [1:0]       modeSel,
  input logic             loadCmd,
  input logic             idxEvent,
  input logic             idxLoadEn,
  input logic             clrFlags,
  input logic [CNT_W-1:0] presetVal,
  input logic [CNT_W-1:0] countOut,
  input logic             carryFlag,
  input logic             borrowFlag,
  input logic             dirFlag
);
  logic anyLoad;
  assign anyLoad = loadCmd || (idxEvent && idxLoadEn);

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    anyLoad |=> countOut == $past(presetVal));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cntStep && !anyLoad) |=> $stable(countOut));

  assert_carry_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (carryFlag && !clrFlags) |=> carryFlag);

  assert_borrow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (borrowFlag && !clrFlags) |=> borrowFlag);

  assert_one_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!carryFlag && !borrowFlag) |=> !(carryFlag && borrowFlag));

  assert_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (modeSel == 2'd1 && cntStep && !cntUp && countOut == '0 && !anyLoad)
      |=> (countOut == '0 && borrowFlag));

  assert_dir_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cntStep |=> dirFlag == $past(cntUp));
endmodule

bind updn_counter updn_counter_chk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rst_n(rst_n), .cntStep(cntStep), .cntUp(cntUp),
  .modeSel(modeSel), .loadCmd(loadCmd), .idxEvent(idxEvent),
  .idxLoadEn(idxLoadEn), .clrFlags(clrFlags), .presetVal(presetVal),
  .countOut(countOut), .carryFlag(carryFlag), .borrowFlag(borrowFlag),
  .dirFlag(dirFlag)
);

// File: tb/tb_updn_counter.sv
module tb_updn_counter;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 24;
  localparam int VW = 1 + W + 2 + 4 + W + 2;
  localparam int NV = 26;
  localparam logic [W-1:0] MX = {W{1'b1}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic cntStep = 0, cntUp = 0, presetWr = 0, loadCmd = 0;
  logic idxEvent = 0, idxLoadEn = 0, clrFlags = 0;
  logic [1:0] modeSel = 0;
  logic [W-1:0] presetIn = 0;
  logic [W-1:0] countOut;
  logic carryFlag, borrowFlag, cmpFlag, signFlag, dirFlag;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  updn_counter dut (.*);

  // vector: wr, preset, mode, load, step, up, clr, expCount, expCarry, expBorrow
  function automatic logic [VW-1:0] V(logic wr, logic [W-1:0] pv, logic [1:0] md,
      logic ld, logic st, logic up, logic cl, logic [W-1:0] ec, logic eC, logic eB);
    return {wr, pv, md, ld, st, up, cl, ec, eC, eB};
  endfunction

  localparam logic [VW-1:0] TBL [NV] = '{
    V(1, 24'd5, 2'd0, 0,0,0,0, 24'd0, 0,0),  // R2 preset write, count holds
    V(0, 24'd0, 2'd0, 1,0,0,0, 24'd5, 0,0),  // R3 transfer
    V(0, 24'd0, 2'd0, 0,1,1,0, 24'd6, 0,0),  // R4 up
    V(0, 24'd0, 2'd0, 0,1,0,0, 24'd5, 0,0),  // R4 down
    V(0, 24'd0, 2'd0, 0,0,0,1, 24'd5, 0,0),  // R8 clear
    V(1, 24'd0, 2'd0, 0,0,0,0, 24'd5, 0,0),  // R2
    V(0, 24'd0, 2'd0, 1,0,0,0, 24'd0, 0,0),  // R3
    V(0, 24'd0, 2'd0, 0,1,0,0, MX,    0,1),  // R4 down wrap
    V(0, 24'd0, 2'd0, 0,1,1,0, 24'd0, 1,1),  // R4 up wrap, R8 both sticky
    V(0, 24'd0, 2'd0, 0,0,0,1, 24'd0, 0,0),  // R8
    V(1, 24'd2, 2'd3, 0,0,0,0, 24'd0, 0,0),  // R7 setup
    V(0, 24'd0, 2'd3, 0,1,1,0, 24'd1, 0,0),  // R7
    V(0, 24'd0, 2'd3, 0,1,1,0, 24'd2, 0,0),  // R7
    V(0, 24'd0, 2'd3, 0,1,1,0, 24'd0, 1,0),  // R7 reload 0
    V(0, 24'd0, 2'd3, 0,1,0,0, 24'd2, 1,1),  // R7 reload preset
    V(0, 24'd0, 2'd1, 0,0,0,1, 24'd2, 0,0),  // R5 setup
    V(0, 24'd0, 2'd1, 0,1,1,0, 24'd2, 1,0),  // R5 ceiling hold
    V(0, 24'd0, 2'd1, 0,1,0,0, 24'd1, 1,0),  // R5
    V(0, 24'd0, 2'd1, 0,1,0,0, 24'd0, 1,0),  // R5
    V(0, 24'd0, 2'd1, 0,1,0,0, 24'd0, 1,1),  // R5 floor hold
    V(0, 24'd0, 2'd2, 0,0,0,1, 24'd0, 0,0),  // R6 setup
    V(0, 24'd0, 2'd2, 0,1,0,0, MX,    0,1),  // R6 wrap
    V(0, 24'd0, 2'd2, 0,1,0,0, MX,    0,1),  // R6 halted
    V(0, 24'd0, 2'd2, 0,1,1,0, MX,    0,1),  // R6 halted
    V(0, 24'd0, 2'd2, 1,0,0,0, 24'd2, 0,1),  // R6 transfer releases
    V(0, 24'd0, 2'd2, 0,1,0,0, 24'd1, 0,1)   // R6 counting again
  };

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, outputs sampled at the following negedge
  task automatic cyc(logic st, logic up, logic ld = 0, logic cl = 0,
                     logic wr = 0, logic [W-1:0] pv = 0, logic ix = 0, logic ie = 0);
    cntStep = st; cntUp = up; loadCmd = ld; clrFlags = cl;
    presetWr = wr; presetIn = pv; idxEvent = ix; idxLoadEn = ie;
    @(negedge clk);
    cntStep = 0; loadCmd = 0; clrFlags = 0; presetWr = 0; idxEvent = 0;
  endtask

  task automatic doReset();
    rst_n = 0; modeSel = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        doReset();
        // R1 reset state
        chk("R1 count", countOut, 0);
        chk("R1 flags", {carryFlag, borrowFlag, cmpFlag, signFlag}, 0);
        chk("R1 dir", dirFlag, 1);
        cyc(0, 0, 1);
        chk("R1 preset zero", countOut, 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
          logic [VW-1:0] v;
          v = TBL[i];
          modeSel = v[VW-26 -: 2];
          cyc(v[VW-29], v[VW-30], v[VW-28], v[VW-31], v[VW-1], v[VW-2 -: W]);
          chk($sformatf("table %0d count", i), countOut, v[W+1:2]);
          chk($sformatf("table %0d carry/borrow", i), {carryFlag, borrowFlag}, v[1:0]);
        end

        // directed corner cases
        doReset();
        cyc(0, 0, 0, 0, 1, 24'd7);
        chk("R2 preset write no count change", countOut, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        chk("R3 index ignored when disabled", countOut, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 1);
        chk("R3 index load", countOut, 7);
        chk("R9 transfer does not set compare", cmpFlag, 0);
        cyc(1, 1, 1);
        chk("R3 transfer beats step", countOut, 7);
        cyc(1, 1);
        chk("R9 no compare at 8", cmpFlag, 0);
        cyc(1, 0);
        chk("R9 compare on step to preset", cmpFlag, 1);
        cyc(0, 0, 0, 0, 1, MX);
        cyc(0, 0, 1);
        chk("R3 load max", countOut, MX);
        cyc(1, 1, 0, 1);
        chk("R4 up wrap to 0", countOut, 0);
        chk("R8 set beats clear", {carryFlag, borrowFlag, cmpFlag}, 3'b100);
        cyc(1, 0);
        chk("R10 sign on borrow", {borrowFlag, signFlag}, 2'b11);
        chk("R11 dir down", dirFlag, 0);
        cyc(1, 1);
        chk("R10 sign cleared by carry", signFlag, 0);
        chk("R8 xor bit", carryFlag ^ borrowFlag, 0);
        chk("R11 dir up", dirFlag, 1);
        cyc(0, 0);
        chk("R11 dir holds without step", dirFlag, 1);
        cyc(1, 0);
        cyc(0, 0, 0, 1);
        chk("R10 R8 clear all", {carryFlag, borrowFlag, cmpFlag, signFlag}, 0);
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule